// File: doc/BRIEF.md
# Packed Pixel Format Unpacker

This block sits between a frame-buffer word fetcher and a colour stage in a display pipeline. It takes 32-bit words on a valid/ready stream and hands out one pixel per cycle on a second valid/ready stream. A pixel is either a palette index, marked by a flag and zero-extended into the low byte of the output, or a direct colour with 8 bits for each of red, green and blue. The pixel depth, the order in which pixels are drawn out of a word, a red/blue exchange and, for the 16-bit depth, an external layout select all set how a word is cut into pixels.

A word is held until its last pixel has left, and the next word is taken in the same cycle, so a stream with no gaps keeps the output busy on every cycle. Narrow colour channels are widened to 8 bits by padding the low bits with zeros. A combinational side output gives the byte length of one line for the column count presented. The configuration inputs are expected to stay still while a word is in flight. A parameter picks the base variant, where the external select sets the 16-bit layout, or the extended variant, where the mode field alone decides it.

Top module: `pix_unpack`

## Requirements
- R1: In the cycle after reset is released, `out_valid` is 0 and `in_ready` is 1.
- R2: `line_bytes` equals `cols` times the pixel size in bits, divided by 8. The size is 1, 2, 4 or 8 bits for modes 0 to 3, 16 bits for modes 4, 6 and 7, and 32 bits for mode 5.
- R3: Modes 0 to 3 (1, 2, 4 and 8 bits) give palette indices: `out_is_index` is 1, `out_data[23:8]` is 0, and the index sits right-aligned in `out_data[7:0]`. With both order inputs low, pixels leave starting from the least significant bits of the word.
- R4: A 1-bit word yields exactly 32 pixels, bit 0 first and bit 31 last, before the next word is accepted.
- R5: With `ord_be_byte` high, pixels leave starting from the most significant end of the word. This holds whatever the value of `ord_be_pix`.
- R6: With only `ord_be_pix` high, bytes are taken from the least significant byte upwards, and the pixels inside each byte are taken from its top bits down.
- R7: Mode 5 gives one pixel per word. Bits 7:0, 15:8 and 23:16 become red, green and blue, and bits 31:24 are ignored. `out_data` is {red, green, blue}, and `out_is_index` is 0. With `swap_rb` high, red and blue exchange places.
- R8: Mode 6 is 5-6-5 with red in bits 4:0, green in 10:5 and blue in 15:11 of each 16-bit half, low half first. Channels widen by shifting left with zero fill.
- R9: In the base variant mode 4 follows `fmt16_sel`. A value of 1 gives 1-5-5-5: red in bits 4:0, green in 9:5, blue in 14:10, bit 15 ignored, `swap_rb` honoured. A value of 3 gives 5-6-5 with red and blue always exchanged. Values 0 and 2 give 5-6-5 with `swap_rb` honoured.
- R10: Mode 7 is 4-4-4 with red in bits 3:0, green in 7:4 and blue in 11:8 of each half. Bits 15:12 are ignored, and each channel becomes {nibble, 4'h0}.
- R11: While `out_valid` is high and `out_ready` is low, `out_data` and `out_is_index` hold, and `in_ready` is 0.
- R12: In the extended variant mode 4 is always 1-5-5-5, and `fmt16_sel` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Pixel depth / format code |
| swap_rb | input | 1 | Exchange red and blue |
| ord_be_byte | input | 1 | Take pixels from the top of the word (wins over ord_be_pix) |
| ord_be_pix | input | 1 | Take pixels from the top of each byte |
| fmt16_sel | input | 2 | External 16-bit layout select (base variant) |
| in_valid | input | 1 | Word available |
| in_ready | output | 1 | Word accepted this cycle when valid |
| in_word | input | 32 | Frame-buffer word |
| out_valid | output | 1 | Pixel available |
| out_ready | input | 1 | Pixel taken this cycle when valid |
| out_is_index | output | 1 | Pixel is a palette index |
| out_data | output | 24 | Index in bits 7:0, or {red, green, blue} |
| cols | input | COLS_W | Column count for the line length |
| line_bytes | output | COLS_W+2 | Bytes per line |

## Verification
The bench builds two instances side by side. One uses the default base variant, so the external 16-bit select is live and all four of its codes can be driven against the red/blue exchange. The other sets the extended parameter, which makes it possible to show that the same select values leave the 16-bit mode in its 1-5-5-5 layout. Both keep the default column width, and that width is wide enough to show the largest line length, four bytes per column.

// File: rtl/pu_pkg.sv
package pu_pkg;

    localparam int WORD_W = 32;
    localparam int IDX_W  = 5;   // log2 of pixels per word at the narrowest depth

    typedef enum logic [2:0] {
        FMT_INDEX,
        FMT_RGB5551,
        FMT_RGB565,
        FMT_RGB444,
        FMT_RGB888
    } pix_fmt_e;

    typedef struct packed {
        logic [2:0] lg_bits;   // log2 of pixel size in bits
        pix_fmt_e   fmt;
        logic       swap;
        logic       is_index;
    } pix_cfg_t;

    function automatic logic [7:0] widen4(input logic [3:0] c);
        return {c, 4'h0};
    endfunction

    function automatic logic [7:0] widen5(input logic [4:0] c);
        return {c, 3'b000};
    endfunction

    function automatic logic [7:0] widen6(input logic [5:0] c);
        return {c, 2'b00};
    endfunction

endpackage

// File: rtl/pu_decode.sv
module pu_decode
    import pu_pkg::*;
#(
    parameter bit EXTENDED = 1'b0
) (
    input  logic [2:0] mode,
    input  logic       swap_rb,
    input  logic [1:0] fmt16_sel,
    output pix_cfg_t   cfg
);
    pix_fmt_e m4_fmt;
    logic     m4_swap;

    generate
        if (EXTENDED) begin : g_ext
            assign m4_fmt  = FMT_RGB5551;
            assign m4_swap = swap_rb;
        end else begin : g_base
            always_comb begin
                m4_fmt  = FMT_RGB565;
                m4_swap = swap_rb;
                case (fmt16_sel)
                    2'd1:    m4_fmt  = FMT_RGB5551;
                    2'd3:    m4_swap = 1'b1;
                    default: ;
                endcase
            end
        end
    endgenerate

    always_comb begin
        cfg.lg_bits  = 3'd4;
        cfg.fmt      = FMT_INDEX;
        cfg.swap     = swap_rb;
        cfg.is_index = 1'b0;
        case (mode)
            3'd0, 3'd1, 3'd2, 3'd3: begin
                cfg.lg_bits  = mode;
                cfg.is_index = 1'b1;
            end
            3'd4: begin
                cfg.fmt  = m4_fmt;
                cfg.swap = m4_swap;
            end
            3'd5: begin
                cfg.lg_bits = 3'd5;
                cfg.fmt     = FMT_RGB888;
            end
            3'd6:    cfg.fmt = FMT_RGB565;
            default: cfg.fmt = FMT_RGB444;
        endcase
    end
endmodule

// File: rtl/pu_seq.sv
module pu_seq
    import pu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic              out_ready,
    input  logic [IDX_W-1:0]  last_idx,
    output logic              in_ready,
    output logic              have,
    output logic [WORD_W-1:0] word_q,
    output logic [IDX_W-1:0]  idx_q
);
    logic at_last;

    assign at_last  = (idx_q == last_idx);
    assign in_ready = !have || (out_ready && at_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            have   <= 1'b0;
            idx_q  <= '0;
            word_q <= '0;
        end else if (have && out_ready) begin
            if (at_last) begin
                if (in_valid) begin
                    word_q <= in_word;
                    idx_q  <= '0;
                end else begin
                    have <= 1'b0;
                end
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end else if (!have && in_valid) begin
            word_q <= in_word;
            idx_q  <= '0;
            have   <= 1'b1;
        end
    end
endmodule

// File: rtl/pu_extract.sv
module pu_extract
    import pu_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [IDX_W-1:0]  idx,
    input  logic [IDX_W-1:0]  last_idx,
    input  pix_cfg_t          cfg,
    input  logic              be_byte,
    input  logic              be_pix,
    output logic [23:0]       pixel
);
    logic [IDX_W-1:0]  in_byte_m1;
    logic [IDX_W-1:0]  slot;
    logic [IDX_W-1:0]  shamt;
    logic [WORD_W-1:0] shifted;
    logic [15:0]       half;
    logic [7:0]        mask;
    logic [7:0]        c0, c1, c2;

    assign in_byte_m1 = (cfg.lg_bits < 3'd3) ? IDX_W'((8 >> cfg.lg_bits) - 1) : '0;

    // byte-order flag overrides pixel-order flag
    assign slot    = be_byte ? (idx ^ last_idx) : be_pix ? (idx ^ in_byte_m1) : idx;
    assign shamt   = slot << cfg.lg_bits;
    assign shifted = word >> shamt;
    assign half    = shifted[15:0];
    assign mask    = 8'((9'd1 << (4'd1 << cfg.lg_bits)) - 9'd1);

    always_comb begin
        c0 = shifted[7:0];
        c1 = shifted[15:8];
        c2 = shifted[23:16];
        case (cfg.fmt)
            FMT_RGB5551: begin
                c0 = widen5(half[4:0]);
                c1 = widen5(half[9:5]);
                c2 = widen5(half[14:10]);
            end
            FMT_RGB565: begin
                c0 = widen5(half[4:0]);
                c1 = widen6(half[10:5]);
                c2 = widen5(half[15:11]);
            end
            FMT_RGB444: begin
                c0 = widen4(half[3:0]);
                c1 = widen4(half[7:4]);
                c2 = widen4(half[11:8]);
            end
            default: ;
        endcase
        if (cfg.is_index)
            pixel = {16'h0000, shifted[7:0] & mask};
        else if (cfg.swap)
            pixel = {c2, c1, c0};
        else
            pixel = {c0, c1, c2};
    end
endmodule

// File: rtl/pix_unpack.sv
module pix_unpack
    import pu_pkg::*;
#(
    parameter bit EXTENDED = 1'b0,
    parameter int COLS_W   = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        mode,
    input  logic              swap_rb,
    input  logic              ord_be_byte,
    input  logic              ord_be_pix,
    input  logic [1:0]        fmt16_sel,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [31:0]       in_word,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_is_index,
    output logic [23:0]       out_data,
    input  logic [COLS_W-1:0] cols,
    output logic [COLS_W+1:0] line_bytes
);
    localparam int LB_W = COLS_W + 5;

    pix_cfg_t          cfg;
    logic [IDX_W-1:0]  last_idx;
    logic [IDX_W-1:0]  idx_q;
    logic [WORD_W-1:0] word_q;
    logic [LB_W-1:0]   bits_per_line;

    pu_decode #(.EXTENDED(EXTENDED)) u_dec (
        .mode      (mode),
        .swap_rb   (swap_rb),
        .fmt16_sel (fmt16_sel),
        .cfg       (cfg)
    );

    assign last_idx = IDX_W'((6'd32 >> cfg.lg_bits) - 6'd1);

    pu_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_word   (in_word),
        .out_ready (out_ready),
        .last_idx  (last_idx),
        .in_ready  (in_ready),
        .have      (out_valid),
        .word_q    (word_q),
        .idx_q     (idx_q)
    );

    pu_extract u_ext (
        .word     (word_q),
        .idx      (idx_q),
        .last_idx (last_idx),
        .cfg      (cfg),
        .be_byte  (ord_be_byte),
        .be_pix   (ord_be_pix),
        .pixel    (out_data)
    );

    assign out_is_index  = cfg.is_index;
    assign bits_per_line = LB_W'(cols) << cfg.lg_bits;
    assign line_bytes    = bits_per_line[LB_W-1:3];
endmodule

// File: rtl/pu_checker.sv
module pu_checker (
    input logic        clk,
    input logic        rst,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic        out_is_index,
    input logic [23:0] out_data
);
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && in_ready));

    a_r3_index_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_is_index) |-> (out_data[23:8] == 16'h0000));

    a_r11_hold_data: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_is_index)));

    a_r11_no_accept: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    a_r4_valid_drops_cleanly: assert property (@(posedge clk) disable iff (rst)
        $fell(out_valid) |-> $past(out_ready));
endmodule

bind pix_unpack pu_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_ready     (in_ready),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_is_index (out_is_index),
    .out_data     (out_data)
);

// File: tb/pix_unpack_test.sv
module pix_unpack_test;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  mode = 3'd3;
    logic        swap_rb = 1'b0, ord_be_byte = 1'b0, ord_be_pix = 1'b0;
    logic [1:0]  fmt16_sel = 2'd0;
    logic        in_valid = 1'b0, in_valid_x = 1'b0;
    logic        out_ready = 1'b0, out_ready_x = 1'b0;
    logic [31:0] in_word = '0;
    logic [10:0] cols = 11'd64;
    logic        in_ready, out_valid, out_is_index;
    logic        in_ready_x, out_valid_x, out_is_index_x;
    logic [23:0] out_data, out_data_x;
    logic [12:0] line_bytes, line_bytes_x;

    int tests = 0;
    int fails = 0;
    logic [23:0] exp_q [32];

    always #(PERIOD/2) clk = ~clk;

    pix_unpack uut (
        .clk(clk), .rst(rst), .mode(mode), .swap_rb(swap_rb),
        .ord_be_byte(ord_be_byte), .ord_be_pix(ord_be_pix), .fmt16_sel(fmt16_sel),
        .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
        .out_valid(out_valid), .out_ready(out_ready), .out_is_index(out_is_index),
        .out_data(out_data), .cols(cols), .line_bytes(line_bytes)
    );

    pix_unpack #(.EXTENDED(1'b1)) uut_ext (
        .clk(clk), .rst(rst), .mode(mode), .swap_rb(swap_rb),
        .ord_be_byte(ord_be_byte), .ord_be_pix(ord_be_pix), .fmt16_sel(fmt16_sel),
        .in_valid(in_valid_x), .in_ready(in_ready_x), .in_word(in_word),
        .out_valid(out_valid_x), .out_ready(out_ready_x), .out_is_index(out_is_index_x),
        .out_data(out_data_x), .cols(cols), .line_bytes(line_bytes_x)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        tests++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    // Feed one word and compare n pixels against exp_q; ext selects the extended instance.
    task automatic run_word(input string tag, input bit ext, input logic [31:0] w,
                            input int n, input logic idx_flag);
        @(negedge clk);
        in_word = w;
        if (ext) begin in_valid_x = 1'b1; out_ready_x = 1'b1; end
        else     begin in_valid   = 1'b1; out_ready   = 1'b1; end
        chk({tag, " ready"}, ext ? in_ready_x : in_ready, 1);
        @(negedge clk);
        in_valid = 1'b0; in_valid_x = 1'b0;
        for (int i = 0; i < n; i++) begin
            chk({tag, " valid"}, ext ? out_valid_x : out_valid, 1);
            chk({tag, " data"}, ext ? out_data_x : out_data, exp_q[i]);
            chk({tag, " flag"}, ext ? out_is_index_x : out_is_index, idx_flag);
            @(negedge clk);
        end
        chk({tag, " drained"}, ext ? out_valid_x : out_valid, 0);
        out_ready = 1'b0; out_ready_x = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 out_valid", out_valid, 0);
        chk("R1 in_ready", in_ready, 1);
    endtask

    task automatic t_line_len;
        mode = 3'd0; #1 chk("R2 1bpp", line_bytes, 8);
        mode = 3'd2; #1 chk("R2 4bpp", line_bytes, 32);
        mode = 3'd3; #1 chk("R2 8bpp", line_bytes, 64);
        mode = 3'd4; #1 chk("R2 16bpp", line_bytes, 128);
        mode = 3'd7; #1 chk("R2 12bpp", line_bytes, 128);
        mode = 3'd5; #1 chk("R2 32bpp", line_bytes, 256);
        cols = 11'd2047; #1 chk("R2 max cols", line_bytes, 8188);
        cols = 11'd64;
    endtask

    task automatic t_index_le;
        mode = 3'd3;
        exp_q[0] = 24'h11; exp_q[1] = 24'h22; exp_q[2] = 24'h33; exp_q[3] = 24'h44;
        run_word("R3 8bpp le", 0, 32'h44332211, 4, 1'b1);
        mode = 3'd2;
        for (int i = 0; i < 8; i++) exp_q[i] = 24'(i);
        run_word("R3 4bpp le", 0, 32'h76543210, 8, 1'b1);
    endtask

    task automatic t_one_bit;
        mode = 3'd0;
        for (int i = 0; i < 32; i++) exp_q[i] = 24'h0;
        exp_q[0] = 24'h1; exp_q[2] = 24'h1; exp_q[31] = 24'h1;
        run_word("R4 1bpp", 0, 32'h80000005, 32, 1'b1);
    endtask

    task automatic t_be_byte;
        mode = 3'd2; ord_be_byte = 1'b1;
        for (int i = 0; i < 8; i++) exp_q[i] = 24'(7 - i);
        run_word("R5 be_byte", 0, 32'h76543210, 8, 1'b1);
        ord_be_pix = 1'b1;
        run_word("R5 both set", 0, 32'h76543210, 8, 1'b1);
        ord_be_byte = 1'b0; ord_be_pix = 1'b0;
    endtask

    task automatic t_be_pix;
        mode = 3'd2; ord_be_pix = 1'b1;
        for (int i = 0; i < 8; i++) exp_q[i] = 24'(i ^ 1);
        run_word("R6 be_pix", 0, 32'h76543210, 8, 1'b1);
        ord_be_pix = 1'b0;
    endtask

    task automatic t_rgb888;
        mode = 3'd5;
        exp_q[0] = 24'hAABBCC;
        run_word("R7 888", 0, 32'h11CCBBAA, 1, 1'b0);
        swap_rb = 1'b1;
        exp_q[0] = 24'hCCBBAA;
        run_word("R7 888 swap", 0, 32'h11CCBBAA, 1, 1'b0);
        swap_rb = 1'b0;
    endtask

    task automatic t_rgb565;
        mode = 3'd6;
        exp_q[0] = 24'h0800F8; exp_q[1] = 24'h00FC00;
        run_word("R8 565", 0, 32'h07E0F801, 2, 1'b0);
    endtask

    task automatic t_mux;
        mode = 3'd4;
        fmt16_sel = 2'd1;
        exp_q[0] = 24'h181008; exp_q[1] = 24'h080000;
        run_word("R9 sel1 5551", 0, 32'h00018443, 2, 1'b0);
        fmt16_sel = 2'd3;
        exp_q[0] = 24'h000008; exp_q[1] = 24'h0;
        run_word("R9 sel3 forced swap", 0, 32'h00000001, 2, 1'b0);
        swap_rb = 1'b1;
        run_word("R9 sel3 swap set", 0, 32'h00000001, 2, 1'b0);
        fmt16_sel = 2'd0;
        exp_q[0] = 24'h000008; exp_q[1] = 24'h00FC00;
        run_word("R9 sel0 swap", 0, 32'h07E00001, 2, 1'b0);
        swap_rb = 1'b0; fmt16_sel = 2'd2;
        exp_q[0] = 24'h080000;
        run_word("R9 sel2 565", 0, 32'h07E00001, 2, 1'b0);
        fmt16_sel = 2'd0;
    endtask

    task automatic t_rgb444;
        mode = 3'd7;
        exp_q[0] = 24'hF050A0; exp_q[1] = 24'hF050A0;
        run_word("R10 444", 0, 32'hFA5F0A5F, 2, 1'b0);
    endtask

    task automatic t_stall;
        mode = 3'd3;
        @(negedge clk);
        in_word = 32'h44332211; in_valid = 1'b1; out_ready = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk("R11 stall valid", out_valid, 1);
            chk("R11 stall data", out_data, 24'h11);
            chk("R11 stall in_ready", in_ready, 0);
            @(negedge clk);
        end
        out_ready = 1'b1;
        @(negedge clk);
        chk("R11 resume data", out_data, 24'h22);
        @(negedge clk); @(negedge clk); @(negedge clk);
        chk("R11 drained", out_valid, 0);
        out_ready = 1'b0;
    endtask

    task automatic t_ext;
        mode = 3'd4;
        exp_q[0] = 24'h181008; exp_q[1] = 24'h00F808;
        fmt16_sel = 2'd3;
        run_word("R12 ext sel3", 1, 32'h07E08443, 2, 1'b0);
        fmt16_sel = 2'd0;
        run_word("R12 ext sel0", 1, 32'h07E08443, 2, 1'b0);
    endtask

    initial begin
        #(PERIOD * 100000);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_line_len();
        t_index_le();
        t_one_bit();
        t_be_byte();
        t_be_pix();
        t_rgb888();
        t_rgb565();
        t_mux();
        t_rgb444();
        t_stall();
        t_ext();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule